// File: doc/BRIEF.md
# One-Time-Programmable Memory Power and Access Sequencer

This block runs one access at a time on a one-time-programmable memory macro. A request gives an address, a write byte and a read-or-program flag. The block then brings up the macro's supplies step by step, waiting a fixed number of clock cycles after each step so the analog regulators can settle. Only after that does it pulse the read or program control pin. When the pulse is over it takes the supplies down again in the opposite order. A read returns its byte on `rd_data`. Every operation ends with a one-cycle `done` pulse.

Power-up order is the low programming supply, then the core supply. For a program operation the high programming voltage comes up last. Shutdown reverses that order. The high voltage is used only by program operations. The memory's test-mode pins stay at 2'b00 permanently. All settle times, the minimum gap between the core supply and the first control pin, the strobe setup and width, the hold time and the shutdown spacing are parameters counted in clock cycles.

The block accepts a request only while idle. A request that arrives while an operation is running is dropped. The address and write byte are captured when a request is accepted, so the memory pins stay still from acceptance until `done`.

Top module: `otp_seq`

## Requirements
- R1: For every operation, `en_vpp_lo` rises in the first cycle after acceptance. `en_vdd` rises T_LO cycles later. `en_vdd` is never high unless `en_vpp_lo` is high.
- R2: For a program operation (`req_prog`=1), `en_vpp_hi` rises T_VDD+T_CEN cycles after `en_vdd`, and rises before `mem_pgm`. For a read, `en_vpp_hi` stays low throughout. `mem_pgm` is never high without `en_vpp_hi`.
- R3: After a program strobe and its hold time, `en_vpp_hi` falls first. `en_vdd` falls T_DN cycles later, and `en_vpp_lo` falls T_DN cycles after that.
- R4: After a read strobe, `mem_rd` falls first. After the hold time, `en_vdd` falls. `en_vpp_lo` falls T_DN cycles after `en_vdd`.
- R5: No control strobe (`mem_rd` or `mem_pgm`) rises until `en_vdd` has been high for at least T_VDD+T_CEN cycles.
- R6: `mem_tmode` is 2'b00 from reset onward in every cycle.
- R7: Each power-up step lasts exactly its parameter in cycles: the low supply step lasts T_LO, the core supply step lasts T_VDD+T_CEN, and the high voltage step lasts T_HI.
- R8: A read captures `mem_rdata` in the last cycle of its strobe. The captured byte is on `rd_data` by the `done` cycle and stays there until the next read. A program operation leaves `rd_data` unchanged.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. `done` is high for exactly one cycle, and in that cycle all three supply enables are low.
- R10: A request while `busy` is high is ignored. The running operation keeps its address and timing, and no second operation follows it.
- R11: From acceptance until `done`, `mem_addr` (and `mem_wdata` for a program) hold the accepted values. A strobe comes T_SU cycles after the last supply step and lasts T_ST cycles. After it, the supplies stay up for T_HD cycles before shutdown begins.
- R12: Only one of `mem_rd` and `mem_pgm` is high at a time, and neither is high outside an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_prog | input | 1 | 1 = program, 0 = read |
| req_addr | input | AW | Memory address of the request |
| req_wdata | input | DW | Bits to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rd_data | output | DW | Last byte read |
| en_vpp_lo | output | 1 | Low programming supply enable |
| en_vdd | output | 1 | Core supply enable |
| en_vpp_hi | output | 1 | High programming voltage enable |
| mem_addr | output | AW | Address to the macro |
| mem_wdata | output | DW | Program data to the macro |
| mem_rd | output | 1 | Read control pin |
| mem_pgm | output | 1 | Program control pin |
| mem_tmode | output | 2 | Test-mode pins, held at 00 |
| mem_rdata | input | DW | Read data from the macro |

## Verification
The bench compares every pin in every cycle of each operation against a timeline it computes from the parameters. This catches a design that swaps two supply steps, keeps the high voltage on during a read, or shortens a settle window. It fires a stray request in the middle of an operation. A design that latches that request would move the address or start a second access. It also checks the measured gap from core-supply rise to strobe rise, which catches a design that strobes too early. A memory model that accepts program pulses only under high voltage, and reads that must return the OR of everything programmed to an address, expose lost program operations and data captured in the wrong cycle.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_UP_LO,
    S_UP_VDD,
    S_UP_HI,
    S_SETUP,
    S_STROBE,
    S_HOLD,
    S_DN_HI,
    S_DN_VDD,
    S_DN_LO
  } seq_state_e;
endpackage

// File: rtl/otp_seq_rstsync.sv
module otp_seq_rstsync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/otp_seq_fsm.sv
module otp_seq_fsm
  import otp_seq_pkg::*;
#(
  parameter int T_LO  = 3,
  parameter int T_VDD = 4,
  parameter int T_CEN = 2,
  parameter int T_HI  = 5,
  parameter int T_SU  = 2,
  parameter int T_ST  = 4,
  parameter int T_HD  = 2,
  parameter int T_DN  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       op_prog,
  output seq_state_e state_q,
  output seq_state_e state_d,
  output logic       step_last,
  output logic       accept
);
  localparam int T_PWR = T_VDD + T_CEN;
  localparam int CW    = $clog2(T_LO + T_PWR + T_HI + T_SU + T_ST + T_HD + T_DN + 2);

  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [CW-1:0] step_len(seq_state_e s);
    case (s)
      S_UP_LO:  return CW'(T_LO - 1);
      S_UP_VDD: return CW'(T_PWR - 1);
      S_UP_HI:  return CW'(T_HI - 1);
      S_SETUP:  return CW'(T_SU - 1);
      S_STROBE: return CW'(T_ST - 1);
      S_HOLD:   return CW'(T_HD - 1);
      S_DN_HI:  return CW'(T_DN - 1);
      S_DN_VDD: return CW'(T_DN - 1);
      default:  return '0;
    endcase
  endfunction

  assign step_last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    if (state_q == S_IDLE) begin
      if (req_valid) begin
        accept  = 1'b1;
        state_d = S_UP_LO;
      end
    end else if (!step_last) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      case (state_q)
        S_UP_LO:  state_d = S_UP_VDD;
        S_UP_VDD: state_d = op_prog ? S_UP_HI : S_SETUP;
        S_UP_HI:  state_d = S_SETUP;
        S_SETUP:  state_d = S_STROBE;
        S_STROBE: state_d = S_HOLD;
        S_HOLD:   state_d = op_prog ? S_DN_HI : S_DN_VDD;
        S_DN_HI:  state_d = S_DN_VDD;
        S_DN_VDD: state_d = S_DN_LO;
        default:  state_d = S_IDLE;
      endcase
    end
    if (state_d != state_q) cnt_d = step_len(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R10: once running, only the step sequence moves the state, never a new request
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && req_valid) |=> (state_q != S_UP_LO || $past(state_q) == S_UP_LO));
endmodule

// File: rtl/otp_seq_latch.sv
module otp_seq_latch #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_prog,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          op_prog,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_prog  <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else if (accept) begin
      op_prog  <= req_prog;
      op_addr  <= req_addr;
      op_wdata <= req_wdata;
    end
  end

  // R11: operands move only on acceptance
  p_operands_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(op_addr) && $stable(op_wdata) && $stable(op_prog)));
endmodule

// File: rtl/otp_seq_pins.sv
module otp_seq_pins
  import otp_seq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int T_VDD = 4,
  parameter int T_CEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state_q,
  input  seq_state_e    state_d,
  input  logic          step_last,
  input  logic          op_prog,
  input  logic [DW-1:0] mem_rdata,
  output logic          en_vpp_lo,
  output logic          en_vdd,
  output logic          en_vpp_hi,
  output logic          mem_rd,
  output logic          mem_pgm,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data
);
  localparam int T_PWR = T_VDD + T_CEN;
  localparam int AGE_W = $clog2(T_PWR + 2);

  logic lo_d, vdd_d, hi_d, rd_d, pgm_d, busy_d, done_d, cap_en;
  logic [AGE_W-1:0] vdd_age_q;

  always_comb begin
    lo_d   = !(state_d inside {S_IDLE, S_DN_LO});
    vdd_d  = state_d inside {S_UP_VDD, S_UP_HI, S_SETUP, S_STROBE, S_HOLD, S_DN_HI};
    hi_d   = op_prog && (state_d inside {S_UP_HI, S_SETUP, S_STROBE, S_HOLD});
    rd_d   = !op_prog && (state_d == S_STROBE);
    pgm_d  = op_prog && (state_d == S_STROBE);
    busy_d = (state_d != S_IDLE);
    done_d = (state_d == S_DN_LO);
    cap_en = (state_q == S_STROBE) && step_last && !op_prog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_vpp_lo <= 1'b0;
      en_vdd    <= 1'b0;
      en_vpp_hi <= 1'b0;
      mem_rd    <= 1'b0;
      mem_pgm   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      en_vpp_lo <= lo_d;
      en_vdd    <= vdd_d;
      en_vpp_hi <= hi_d;
      mem_rd    <= rd_d;
      mem_pgm   <= pgm_d;
      busy      <= busy_d;
      done      <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (cap_en) rd_data <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         vdd_age_q <= '0;
    else if (!en_vdd)                   vdd_age_q <= '0;
    else if (vdd_age_q != AGE_W'(T_PWR)) vdd_age_q <= vdd_age_q + 1'b1;
  end

  p_vdd_needs_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en_vdd |-> en_vpp_lo);
  p_hi_needs_vdd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_vpp_hi |-> en_vdd);
  p_pgm_under_hv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pgm |-> en_vpp_hi);
  p_hv_gone_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_vdd) |-> !$past(en_vpp_hi));
  p_rd_gone_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_vdd) |-> !$past(mem_rd));
  p_ctrl_after_cen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_rd) || $rose(mem_pgm)) |-> (vdd_age_q >= AGE_W'(T_PWR)));
  p_done_powered_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !en_vpp_lo && !en_vdd && !en_vpp_hi));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_pgm}));
endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_seq_pkg::*;
#(
  parameter int AW    = 7,
  parameter int DW    = 8,
  parameter int T_LO  = 3,
  parameter int T_VDD = 4,
  parameter int T_CEN = 2,
  parameter int T_HI  = 5,
  parameter int T_SU  = 2,
  parameter int T_ST  = 4,
  parameter int T_HD  = 2,
  parameter int T_DN  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_prog,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          en_vpp_lo,
  output logic          en_vdd,
  output logic          en_vpp_hi,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_pgm,
  output logic [1:0]    mem_tmode,
  input  logic [DW-1:0] mem_rdata
);
  logic       rst_ns;
  logic       accept, step_last, op_prog;
  seq_state_e state_q, state_d;

  otp_seq_rstsync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  otp_seq_fsm #(
    .T_LO(T_LO), .T_VDD(T_VDD), .T_CEN(T_CEN), .T_HI(T_HI),
    .T_SU(T_SU), .T_ST(T_ST), .T_HD(T_HD), .T_DN(T_DN)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_ns),
    .req_valid (req_valid),
    .op_prog   (op_prog),
    .state_q   (state_q),
    .state_d   (state_d),
    .step_last (step_last),
    .accept    (accept)
  );

  otp_seq_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk       (clk),
    .rst_n     (rst_ns),
    .accept    (accept),
    .req_prog  (req_prog),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .op_prog   (op_prog),
    .op_addr   (mem_addr),
    .op_wdata  (mem_wdata)
  );

  otp_seq_pins #(.DW(DW), .T_VDD(T_VDD), .T_CEN(T_CEN)) u_pins (
    .clk       (clk),
    .rst_n     (rst_ns),
    .state_q   (state_q),
    .state_d   (state_d),
    .step_last (step_last),
    .op_prog   (op_prog),
    .mem_rdata (mem_rdata),
    .en_vpp_lo (en_vpp_lo),
    .en_vdd    (en_vdd),
    .en_vpp_hi (en_vpp_hi),
    .mem_rd    (mem_rd),
    .mem_pgm   (mem_pgm),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data)
  );

  assign mem_tmode = 2'b00;

  // R11: address never moves under an active strobe
  p_addr_still_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    ((mem_rd || mem_pgm) && $past(mem_rd || mem_pgm)) |-> $stable(mem_addr));
  // R12: no strobe outside an operation
  p_strobe_in_op_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_rd || mem_pgm) |-> busy);
endmodule

// File: tb/otp_seq_tb.sv
module otp_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7, DW = 8;
  localparam int T_LO = 3, T_VDD = 4, T_CEN = 2, T_HI = 5;
  localparam int T_SU = 2, T_ST = 4, T_HD = 2, T_DN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_prog = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, done, en_vpp_lo, en_vdd, en_vpp_hi, mem_rd, mem_pgm;
  logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_tmode;

  logic [DW-1:0] cells  [0:(1<<AW)-1];
  logic [DW-1:0] shadow [0:(1<<AW)-1];
  logic [DW-1:0] last_rd;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_seq #(
    .AW(AW), .DW(DW), .T_LO(T_LO), .T_VDD(T_VDD), .T_CEN(T_CEN), .T_HI(T_HI),
    .T_SU(T_SU), .T_ST(T_ST), .T_HD(T_HD), .T_DN(T_DN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prog(req_prog),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .en_vpp_lo(en_vpp_lo), .en_vdd(en_vdd), .en_vpp_hi(en_vpp_hi),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_pgm(mem_pgm),
    .mem_tmode(mem_tmode), .mem_rdata(mem_rdata)
  );

  // memory macro model: bits only set under program pulse with high voltage
  always @(posedge clk)
    if (mem_pgm && en_vpp_hi && en_vdd) cells[mem_addr] <= cells[mem_addr] | mem_wdata;
  assign mem_rdata = (mem_rd && en_vdd) ? cells[mem_addr] : '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int op_len(bit prog);
    return T_LO + T_VDD + T_CEN + (prog ? T_HI : 0) + T_SU + T_ST + T_HD
           + (prog ? T_DN : 0) + T_DN + 1;
  endfunction

  // expected {lo,vdd,hi,rd,pgm,busy,done} i cycles after acceptance
  function automatic logic [6:0] exp_pins(bit prog, int i);
    int b1, b2, b3, b4, b5, b6, b7, b8;
    b1 = T_LO; b2 = b1 + T_VDD + T_CEN; b3 = b2 + (prog ? T_HI : 0);
    b4 = b3 + T_SU; b5 = b4 + T_ST; b6 = b5 + T_HD;
    b7 = b6 + (prog ? T_DN : 0); b8 = b7 + T_DN;
    if (i < b1) return 7'b1000010;
    if (i < b2) return 7'b1100010;
    if (i < b3) return 7'b1110010;
    if (i < b4) return {3'b110 | {2'b00, prog}, 4'b0010};
    if (i < b5) return {2'b11, prog, !prog, prog, 2'b10};
    if (i < b6) return {2'b11, prog, 4'b0010};
    if (i < b7) return 7'b1100010;
    if (i < b8) return 7'b1000010;
    return 7'b0000011;
  endfunction

  function automatic string phase_tag(bit prog, int i);
    int b2, b3, b6, b7, b8;
    b2 = T_LO + T_VDD + T_CEN; b3 = b2 + (prog ? T_HI : 0);
    b6 = b3 + T_SU + T_ST + T_HD; b7 = b6 + (prog ? T_DN : 0); b8 = b7 + T_DN;
    if (i < b2) return "R1 R7";
    if (i < b3) return "R2 R7";
    if (i < b6) return "R11 R12";
    if (i < b7) return "R3";
    if (i < b8) return (prog ? "R3" : "R4");
    return "R9";
  endfunction

  task automatic run_op(input bit prog, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wdata, input bit inject);
    int tot, vdd_at, stb_at;
    logic [6:0] act;
    tot = op_len(prog); vdd_at = -1; stb_at = -1;
    @(negedge clk);
    req_valid = 1'b1; req_prog = prog; req_addr = addr; req_wdata = wdata;
    for (int i = 0; i < tot; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      if (inject && i == 2) begin
        req_valid = 1'b1; req_prog = !prog; req_addr = addr ^ 7'h55; req_wdata = ~wdata;
      end
      if (inject && i == 3) req_valid = 1'b0;
      act = {en_vpp_lo, en_vdd, en_vpp_hi, mem_rd, mem_pgm, busy, done};
      check(act == exp_pins(prog, i), phase_tag(prog, i), "pins", act, exp_pins(prog, i));
      check(mem_addr == addr && (!prog || mem_wdata == wdata), inject ? "R10 R11" : "R11",
            "operands", {mem_addr, mem_wdata}, {addr, wdata});
      if (mem_tmode != 2'b00) check(1'b0, "R6", "tmode", mem_tmode, 0);
      if (en_vdd && vdd_at < 0) vdd_at = i;
      if ((mem_rd || mem_pgm) && stb_at < 0) stb_at = i;
      if (done) begin
        if (prog) begin
          shadow[addr] = shadow[addr] | wdata;
          check(rd_data == last_rd, "R8", "rd_data kept over program", rd_data, last_rd);
        end else begin
          check(rd_data == shadow[addr], "R8", "read data", rd_data, shadow[addr]);
          last_rd = shadow[addr];
        end
      end
    end
    check(stb_at - vdd_at >= T_VDD + T_CEN, "R5", "vdd to strobe gap", stb_at - vdd_at, T_VDD + T_CEN);
    @(posedge clk);
    @(negedge clk);
    check(!busy && !en_vpp_lo, inject ? "R10" : "R9", "idle after done", {busy, en_vpp_lo}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h0715_5eed));
    for (int a = 0; a < (1 << AW); a++) begin cells[a] = '0; shadow[a] = '0; end
    last_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, done, en_vpp_lo, en_vdd, en_vpp_hi, mem_rd, mem_pgm} == 7'b0 && rd_data == '0,
          "R9", "reset state", {busy, done, en_vpp_lo, en_vdd, en_vpp_hi, mem_rd, mem_pgm}, 0);
    check(mem_tmode == 2'b00, "R6", "tmode after reset", mem_tmode, 0);

    run_op(1'b0, 7'd5, 8'h00, 1'b0);          // blank read
    run_op(1'b1, 7'd5, 8'hA5, 1'b0);          // program
    run_op(1'b0, 7'd5, 8'h00, 1'b0);          // read back
    run_op(1'b1, 7'd5, 8'h0F, 1'b0);          // add bits
    run_op(1'b0, 7'd5, 8'h00, 1'b0);
    run_op(1'b0, 7'd127, 8'h00, 1'b1);        // stray request during read
    run_op(1'b1, 7'd0, 8'hFF, 1'b1);          // stray request during program
    run_op(1'b0, 7'd0, 8'h00, 1'b0);

    for (int n = 0; n < 40; n++) begin
      bit p;
      p = ($urandom % 3) == 0;
      run_op(p, 7'($urandom % 16), 8'($urandom), ($urandom % 4) == 0);
    end
    finish_run();
  end
endmodule